// File: doc/BRIEF.md
# Dual-Modulus Programmable Feedback Divider

This block divides a fast input clock by a programmable ratio N for the feedback path of a frequency synthesiser loop. The ratio is split into a main count M (upper bits) and a swallow count A (lower `A_W` bits), so N = 16·M + A with the default 4-bit swallow field. Each division has M sub-cycles. The first A sub-cycles last 17 input ticks and the rest last 16.

A static divide-by-two stage can be placed in front of the counters. When it is selected, each division lasts 2·N input clocks. This doubles the tuning step. The selection is static: it may only be changed while reset is held.

The block produces three outputs:
- a divided pulse for the phase detector;
- a one-cycle terminal-count strobe, which marks the point where a new ratio is taken in;
- a half-rate copy of the division for test access.

A ratio too small to satisfy M ≥ A is replaced by the smallest legal ratio, and a flag reports that this happened.

Top module: `rf_mna_divider`

## Requirements
- R1: While `rst` is high, `tc_strobe`, `fpd_out`, `fpd_half` and `ratio_clamped` all read 0 one clock after reset is applied.
- R2: With `pre_en` = 0 and a legal ratio N (M = `div_ratio` above the low `A_W` bits, A = the low `A_W` bits), `tc_strobe` pulses every N clocks. The first pulse is seen N clocks after the first rising edge that follows reset release.
- R3: `tc_strobe` is high for exactly one clock per division.
- R4: With `pre_en` = 1, the strobe period and the first-pulse delay are 2·N clocks.
- R5: The ratio present on `div_ratio` at the clock edge that ends a division governs the next whole division. A change made in the middle of a division does not alter that division.
- R6: A ratio below (2^A_W − 1)·2^A_W (240 for `A_W` = 4) is divided as exactly that minimum. `ratio_clamped` reads 1 one clock after such a ratio is applied, and 0 one clock after a legal ratio is applied.
- R7: With `pre_en` = 0, `fpd_out` is high exactly in the strobe cycle. With `pre_en` = 1, it is high in the cycle before the strobe and in the strobe cycle.
- R8: `fpd_half` changes value only in, and in every, cycle in which `tc_strobe` is high.
- R9: The division ratio reaches its maximum of 2^(M_W+A_W) − 1 without wrapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock being divided |
| rst | input | 1 | Synchronous active-high reset |
| div_ratio | input | M_W+A_W | Requested ratio N; upper bits M, low A_W bits A |
| pre_en | input | 1 | Selects the divide-by-two front stage (static) |
| fpd_out | output | 1 | Divided pulse toward the phase detector |
| tc_strobe | output | 1 | One-cycle terminal-count strobe per division |
| fpd_half | output | 1 | Divided output halved, for test |
| ratio_clamped | output | 1 | Requested ratio was below the legal minimum |

## Verification
The bench builds the divider with `M_W` = 7 and keeps `A_W` = 4. This lowers the maximum ratio to 2047, or 4094 clocks with the front stage enabled. The all-ones ratio can then be tested in full, together with the 240 floor, all-15 swallow counts, and the M = A boundary at 255.

The bench predicts the strobe instant of every division from the ratio in force and compares that prediction in every cycle. It does this across:
- ratio changes made mid-division;
- a clamped request;
- a second reset session with the front stage enabled.

// File: rtl/rfdiv_pkg.sv
package rfdiv_pkg;
  // Modulus selected by the dual-modulus stage for the current sub-cycle
  typedef enum logic {
    MOD_BASE  = 1'b0,   // 2**A_W ticks
    MOD_PLUS1 = 1'b1    // 2**A_W + 1 ticks (swallow sub-cycle)
  } mod_sel_e;
endpackage

// File: rtl/rfdiv_ratio_guard.sv
module rfdiv_ratio_guard #(
  parameter int M_W = 13,
  parameter int A_W = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [M_W+A_W-1:0] ratio_in,
  output logic [M_W-1:0]     m_val,
  output logic [A_W-1:0]     a_val,
  output logic               clamped
);
  localparam int N_W = M_W + A_W;
  // Smallest ratio with M >= largest A: M = 2**A_W - 1, A = 0
  localparam logic [N_W-1:0] N_MIN = N_W'((2**A_W - 1) * (2**A_W));

  logic           too_small;
  logic [N_W-1:0] eff;

  always_comb begin
    too_small = (ratio_in < N_MIN);
    eff       = too_small ? N_MIN : ratio_in;
    m_val     = eff[N_W-1:A_W];
    a_val     = eff[A_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) clamped <= 1'b0;
    else     clamped <= too_small;
  end

  AST_CLAMP_FLAG: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) && $past(ratio_in < N_MIN) |-> clamped) else $error("clamp flag missing"); // R6
endmodule

// File: rtl/rfdiv_front_div2.sv
module rfdiv_front_div2 (
  input  logic clk,
  input  logic rst,
  input  logic pre_en,
  output logic tick
);
  logic ph;

  always_ff @(posedge clk) begin
    if (rst)         ph <= 1'b0;
    else if (pre_en) ph <= ~ph;
    else             ph <= 1'b0;
  end

  assign tick = pre_en ? ph : 1'b1;

  AST_TICK_ALTERNATES: assert property (@(posedge clk) disable iff (rst)
    pre_en && tick |=> !tick) else $error("front stage tick not halved"); // R4
endmodule

// File: rtl/rfdiv_dual_mod.sv
module rfdiv_dual_mod
  import rfdiv_pkg::*;
#(
  parameter int A_W = 4
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     tick,
  input  mod_sel_e mod_sel,
  output logic     sub_last
);
  localparam int P_W = A_W + 1;
  localparam logic [P_W-1:0] LAST_BASE  = P_W'(2**A_W - 1);
  localparam logic [P_W-1:0] LAST_PLUS1 = P_W'(2**A_W);

  logic [P_W-1:0] pc;

  assign sub_last = (pc == ((mod_sel == MOD_PLUS1) ? LAST_PLUS1 : LAST_BASE));

  always_ff @(posedge clk) begin
    if (rst)       pc <= '0;
    else if (tick) pc <= sub_last ? '0 : pc + 1'b1;
  end

  AST_PC_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    pc <= LAST_PLUS1) else $error("prescaler count out of range"); // R2
endmodule

// File: rtl/rfdiv_swallow_ctrl.sv
module rfdiv_swallow_ctrl
  import rfdiv_pkg::*;
#(
  parameter int M_W = 13,
  parameter int A_W = 4
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           tick,
  input  logic           sub_last,
  input  logic [M_W-1:0] m_new,
  input  logic [A_W-1:0] a_new,
  output mod_sel_e       mod_sel,
  output logic           div_last
);
  localparam logic [M_W-1:0] M_ONE = M_W'(1);

  logic [M_W-1:0] m_rem;
  logic [A_W-1:0] a_rem;

  assign mod_sel  = (a_rem != '0) ? MOD_PLUS1 : MOD_BASE;
  assign div_last = sub_last && (m_rem == M_ONE);

  always_ff @(posedge clk) begin
    if (rst) begin
      m_rem <= m_new;
      a_rem <= a_new;
    end else if (tick && sub_last) begin
      if (m_rem == M_ONE) begin
        m_rem <= m_new;
        a_rem <= a_new;
      end else begin
        m_rem <= m_rem - 1'b1;
        if (a_rem != '0) a_rem <= a_rem - 1'b1;
      end
    end
  end

  AST_SWALLOW_LE_MAIN: assert property (@(posedge clk) disable iff (rst)
    M_W'(a_rem) <= m_rem) else $error("swallow count exceeds main count"); // R2
  AST_MAIN_NONZERO: assert property (@(posedge clk) disable iff (rst)
    m_rem != '0) else $error("main count reached zero"); // R9
endmodule

// File: rtl/rf_mna_divider.sv
module rf_mna_divider
  import rfdiv_pkg::*;
#(
  parameter int M_W = 13,
  parameter int A_W = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [M_W+A_W-1:0] div_ratio,
  input  logic               pre_en,
  output logic               fpd_out,
  output logic               tc_strobe,
  output logic               fpd_half,
  output logic               ratio_clamped
);
  logic [M_W-1:0] m_val;
  logic [A_W-1:0] a_val;
  logic           tick;
  logic           sub_last;
  logic           div_last;
  mod_sel_e       mod_sel;

  rfdiv_ratio_guard #(.M_W(M_W), .A_W(A_W)) u_guard (
    .clk(clk), .rst(rst), .ratio_in(div_ratio),
    .m_val(m_val), .a_val(a_val), .clamped(ratio_clamped)
  );

  rfdiv_front_div2 u_front (
    .clk(clk), .rst(rst), .pre_en(pre_en), .tick(tick)
  );

  rfdiv_dual_mod #(.A_W(A_W)) u_dmod (
    .clk(clk), .rst(rst), .tick(tick), .mod_sel(mod_sel), .sub_last(sub_last)
  );

  rfdiv_swallow_ctrl #(.M_W(M_W), .A_W(A_W)) u_ctrl (
    .clk(clk), .rst(rst), .tick(tick), .sub_last(sub_last),
    .m_new(m_val), .a_new(a_val), .mod_sel(mod_sel), .div_last(div_last)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      tc_strobe <= 1'b0;
      fpd_out   <= 1'b0;
      fpd_half  <= 1'b0;
    end else begin
      tc_strobe <= tick && div_last;
      fpd_out   <= div_last;
      fpd_half  <= fpd_half ^ (tick && div_last);
    end
  end

  AST_TC_SINGLE: assert property (@(posedge clk) disable iff (rst)
    tc_strobe |=> !tc_strobe) else $error("strobe longer than one cycle"); // R3
  AST_TC_HAS_FPD: assert property (@(posedge clk) disable iff (rst)
    tc_strobe |-> fpd_out) else $error("divided pulse missing at strobe"); // R7
  AST_HALF_ON_TC: assert property (@(posedge clk) disable iff (rst)
    (fpd_half != $past(fpd_half)) |-> tc_strobe) else $error("half output moved off strobe"); // R8
endmodule

// File: tb/rf_mna_divider_bench.sv
module rf_mna_divider_bench;
  localparam int M_W = 7;
  localparam int A_W = 4;
  localparam int NW  = M_W + A_W;
  localparam int NMIN = (2**A_W - 1) * (2**A_W);

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [NW-1:0] div_ratio = '0;
  logic          pre_en = 1'b0;
  logic          fpd_out, tc_strobe, fpd_half, ratio_clamped;

  int  checks = 0;
  int  fails  = 0;
  int  cnt    = 0;
  int  last   = 0;
  bit  exp_half = 1'b0;
  bit  done   = 1'b0;
  int  q[$];

  always #2 clk = ~clk;   // 250 MHz

  rf_mna_divider #(.M_W(M_W), .A_W(A_W)) u_rf_mna_divider (
    .clk(clk), .rst(rst), .div_ratio(div_ratio), .pre_en(pre_en),
    .fpd_out(fpd_out), .tc_strobe(tc_strobe), .fpd_half(fpd_half),
    .ratio_clamped(ratio_clamped)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cnt);
    end
  endtask

  function automatic int eff_period(input int r, input bit pre);
    int n;
    n = (r < NMIN) ? NMIN : r;
    return pre ? 2 * n : n;
  endfunction

  always @(posedge clk) begin
    if (rst) cnt <= 0;
    else     cnt <= cnt + 1;
  end

  // Monitor: pops expected division lengths and checks every cycle
  always @(negedge clk) begin
    if (rst) begin
      last     = 0;
      exp_half = 1'b0;
    end else if (q.size() > 0) begin
      int  exp_end;
      bit  exp_tc, exp_fpd;
      exp_end = last + q[0];
      exp_tc  = (cnt == exp_end);
      exp_fpd = exp_tc || (pre_en && cnt == exp_end - 1);
      if (exp_tc) exp_half = ~exp_half;
      chk(pre_en ? "R4 strobe timing" : "R2 strobe timing", int'(tc_strobe), int'(exp_tc));
      chk("R7 divided pulse", int'(fpd_out), int'(exp_fpd));
      chk("R8 half output", int'(fpd_half), int'(exp_half));
      if (exp_tc) begin
        last = cnt;
        void'(q.pop_front());
      end
    end
  end

  // Checks R3 separately: strobe never held two cycles
  bit prev_tc = 1'b0;
  always @(negedge clk) begin
    if (!rst && prev_tc && tc_strobe) chk("R3 strobe width", 1, 0);
    prev_tc = tc_strobe;
  end

  task automatic start(input bit pre, input int r0);
    @(negedge clk);
    rst = 1'b1;
    pre_en = pre;
    div_ratio = NW'(r0);
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 reset strobe", int'(tc_strobe), 0);
    chk("R1 reset pulse", int'(fpd_out), 0);
    chk("R1 reset half", int'(fpd_half), 0);
    chk("R1 reset flag", int'(ratio_clamped), 0);
    q.delete();
    q.push_back(eff_period(r0, pre));  // first division
    q.push_back(eff_period(r0, pre));  // division starting at first strobe
    rst = 1'b0;
  endtask

  // R5: new ratio set just after a strobe governs the division after the current one
  task automatic next_ratio(input int r);
    do @(negedge clk); while (!tc_strobe);
    div_ratio = NW'(r);
    q.push_back(eff_period(r, pre_en));
    @(negedge clk);
    chk("R6 clamp flag", int'(ratio_clamped), (r < NMIN) ? 1 : 0);
  endtask

  task automatic drain();
    while (q.size() != 0) @(negedge clk);
  endtask

  initial begin
    // Session 1: front stage off
    start(1'b0, 240);
    next_ratio(241);
    next_ratio(255);     // M = A = 15
    next_ratio(256);
    next_ratio(1000);
    next_ratio(100);     // R6 clamp to 240
    next_ratio(2047);    // R9 all-ones ratio
    next_ratio(300);
    drain();
    // Session 2: front stage on
    start(1'b1, 300);
    next_ratio(239);     // R6 clamp, doubled
    next_ratio(2047);    // R9 doubled maximum
    next_ratio(259);
    drain();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule